// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Event Counter

This block is a 16-bit up-counter steered by a small control register. A three-bit mode field in that register picks one of four behaviours: halted with the count held at zero, free-running with natural wrap-around, restart from zero on each qualified edge of an external event pin, or restart from zero when the count reaches compare register 0. Two compare registers feed a match interrupt pulse and a toggle output. The low bit of each mode pair decides whether a qualified external edge also inverts the toggle output. A sticky overflow flag records every step of the count from FFFFh to 0000h.

Software reaches the block through a plain register port. The port has a write strobe with address and data, and a separate combinational read address with read data. There is no streaming data path, so no valid/ready handshake is involved and no input is ever back-pressured. Counting advances only on cycles where the `tick` input is high, which lets an external prescaler set the rate. The external event pin may be asynchronous. It is resynchronised inside the block, and a two-bit input chooses which of its edges count as qualified.

Top module: `evt_timer16`

## Requirements
- R1: Address 0 reads the control word: bits 15:4 read zero, bits 3:1 hold the mode and bit 0 holds the overflow flag. All of these are 0 after reset. Address 1 holds compare 0, address 2 holds compare 1, and address 3 reads the counter. Compare writes land on the next clock edge.
- R2: In modes 000 and 001 the counter is cleared to zero on every clock edge, the toggle output keeps its value and `irq` stays low.
- R3: In modes 010 and 011 each clock edge with `tick` high adds one to the counter, wrapping from FFFFh to 0000h.
- R4: In modes 100 and 101 a qualified edge clears the counter to zero on that clock edge, whether or not `tick` is high. Otherwise the counter counts as in R3.
- R5: In modes 110 and 111, a clock edge with `tick` high and the counter equal to compare 0 loads zero into the counter. Otherwise the counter counts as in R3.
- R6: In every mode other than 000/001, a clock edge with `tick` high and the counter equal to compare 0 or compare 1 makes `irq` high for exactly the following cycle.
- R7: In every mode other than 000/001, the toggle output inverts one cycle after a match event as defined in R6. In the odd running modes (011, 101, 111) it also inverts after a qualified edge. Simultaneous causes give a single inversion. The output is 0 after reset.
- R8: The overflow flag is set when a running counter at FFFFh sees `tick`, unless a qualified edge in modes 100/101 clears the counter on that same edge. The flag stays set until software writes bit 0 as 0. A hardware set wins over a software clear in the same cycle.
- R9: While the mode is running, a control write is only taken if its mode bits equal the current mode or select a stop code (000/001); otherwise the mode is left unchanged. Bit 0 of every control write is always taken.
- R10: `ext_in` passes two synchroniser flops before edge detection. A change that is set up before one clock edge acts on the third edge. `edge_sel` 01 qualifies rising edges, 10 falling edges, 11 both, and 00 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 compare 0, 2 compare 1) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 compare 0, 2 compare 1, 3 counter) |
| rd_data | output | 16 | Combinational read data |
| tick | input | 1 | Count-enable for the current cycle |
| ext_in | input | 1 | External event pin, may be asynchronous |
| edge_sel | input | 2 | Qualified edge choice for `ext_in` |
| tog_out | output | 1 | Toggle output |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
The properties assume that `tick`, the write strobe and the write fields are synchronous to `clk`, and that reset is asserted before the first edge. Only `ext_in` may change at arbitrary times, because the properties look at the synchronised edge pulse and never at the raw pin. The bench changes every input a short delay after a rising edge. It uses only the four legal addresses and leaves `tick` as a per-cycle level, so the match, clear and overflow properties always see the stable values the design sees.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int MODE_W   = 3;
  localparam int MODE_LSB = 1;
  localparam int OVF_BIT  = 0;
  localparam int EDGE_TOG_BIT = 0;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP0 = 2'd1;
  localparam logic [1:0] ADDR_CMP1 = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  typedef enum logic [1:0] {
    GRP_STOP      = 2'd0,
    GRP_FREE      = 2'd1,
    GRP_EDGE_CLR  = 2'd2,
    GRP_MATCH_CLR = 2'd3
  } grp_e;

  function automatic grp_e grp_of(input logic [MODE_W-1:0] m);
    return grp_e'(m[MODE_W-1:1]);
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       edge_pulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= 1'b0;
    else        pipe[0] <= din;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= SYNC_STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[gi] <= 1'b0;
        else        pipe[gi] <= pipe[gi-1];
      end
    end
  endgenerate

  logic now_v, old_v;
  assign now_v = pipe[LAST];
  assign old_v = pipe[SYNC_STAGES];

  assign edge_pulse = (edge_sel[0] &  now_v & ~old_v) |
                      (edge_sel[1] & ~now_v &  old_v);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ovf_set,
  output logic [MODE_W-1:0] mode,
  output logic              ovf,
  output logic [CNT_W-1:0]  cmp0,
  output logic [CNT_W-1:0]  cmp1
);
  logic [MODE_W-1:0] new_mode;
  logic              ctrl_wr, mode_ok;

  assign new_mode = wr_data[MODE_LSB +: MODE_W];
  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign mode_ok  = (grp_of(mode) == GRP_STOP) ||
                    (grp_of(new_mode) == GRP_STOP) ||
                    (new_mode == mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      ovf  <= 1'b0;
      cmp0 <= '0;
      cmp1 <= '0;
    end else begin
      if (ctrl_wr) begin
        if (mode_ok) mode <= new_mode;
        ovf <= wr_data[OVF_BIT] | ovf_set;
      end else if (ovf_set) begin
        ovf <= 1'b1;
      end
      if (wr_en && wr_addr == ADDR_CMP0) cmp0 <= wr_data;
      if (wr_en && wr_addr == ADDR_CMP1) cmp1 <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              tick,
  input  logic              edge_pulse,
  input  logic [CNT_W-1:0]  cmp0,
  input  logic [CNT_W-1:0]  cmp1,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_set,
  output logic              tog_out,
  output logic              irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  grp_e grp;
  logic run, hit0, hit1, edge_clr, wrap_clr, tog_ev;
  logic [CNT_W-1:0] cnt_nxt;

  assign grp      = grp_of(mode);
  assign run      = (grp != GRP_STOP);
  assign hit0     = run && tick && (cnt == cmp0);
  assign hit1     = run && tick && (cnt == cmp1);
  assign edge_clr = (grp == GRP_EDGE_CLR) && edge_pulse;
  assign wrap_clr = (grp == GRP_MATCH_CLR) && (cnt == cmp0);
  assign ovf_set  = run && tick && (&cnt) && !edge_clr;
  assign tog_ev   = run && (hit0 || hit1 || (mode[EDGE_TOG_BIT] && edge_pulse));

  always_comb begin
    if (!run)          cnt_nxt = '0;
    else if (edge_clr) cnt_nxt = '0;
    else if (tick)     cnt_nxt = wrap_clr ? '0 : cnt + ONE;
    else               cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tog_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      tog_out <= tog_out ^ tog_ev;
      irq     <= hit0 | hit1;
    end
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tick,
  input  logic             ext_in,
  input  logic [1:0]       edge_sel,
  output logic             tog_out,
  output logic             irq
);
  localparam int CTRL_PAD = CNT_W - MODE_W - 1;

  logic [MODE_W-1:0] mode_q;
  logic              ovf_q, ovf_set, edge_pulse;
  logic [CNT_W-1:0]  cmp0_q, cmp1_q, cnt_q;

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in), .edge_sel(edge_sel),
    .edge_pulse(edge_pulse)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ovf_set(ovf_set), .mode(mode_q), .ovf(ovf_q),
    .cmp0(cmp0_q), .cmp1(cmp1_q)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick),
    .edge_pulse(edge_pulse), .cmp0(cmp0_q), .cmp1(cmp1_q), .cnt(cnt_q),
    .ovf_set(ovf_set), .tog_out(tog_out), .irq(irq)
  );

  always_comb begin
    case (rd_addr)
      ADDR_CTRL: rd_data = {{CTRL_PAD{1'b0}}, mode_q, ovf_q};
      ADDR_CMP0: rd_data = cmp0_q;
      ADDR_CMP1: rd_data = cmp1_q;
      default:   rd_data = cnt_q;
    endcase
  end
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [MODE_W-1:0] mode,
  input logic              ovf,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp0,
  input logic [CNT_W-1:0]  cmp1,
  input logic              edge_pulse,
  input logic              irq,
  input logic              tog_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  grp_e grp;
  logic run;
  assign grp = grp_of(mode);
  assign run = (grp != GRP_STOP);

  p_stop_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!irq && $stable(tog_out)));

  p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_FREE && tick) |=> cnt == $past(cnt) + ONE);

  p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_EDGE_CLR && edge_pulse) |=> cnt == '0);

  p_match_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_MATCH_CLR && tick && cnt == cmp0) |=> cnt == '0);

  p_irq_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (cnt == cmp0 || cnt == cmp1)) |=> irq);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run && tick));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && (&cnt) && !(grp == GRP_EDGE_CLR && edge_pulse)) |=> ovf);

  p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(mode) || grp_of(mode) == GRP_STOP));
endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .ovf(ovf_q),
  .cnt(cnt_q), .cmp0(cmp0_q), .cmp1(cmp1_q), .edge_pulse(edge_pulse),
  .irq(irq), .tog_out(tog_out)
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd3;
  logic [15:0] rd_data;
  logic        tick = 1'b0;
  logic        ext_in = 1'b0;
  logic [1:0]  edge_sel = 2'b01;
  logic        tog_out, irq;

  integer total = 0, bad = 0;
  bit     done = 1'b0;

  always #10 clk = ~clk;

  evt_timer16 u_evt_timer16 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick),
    .ext_in(ext_in), .edge_sel(edge_sel), .tog_out(tog_out), .irq(irq)
  );

  // reference model state
  bit [2:0]  m_mode;
  bit        m_ovf, m_tog, m_irq, s1, s2, s3;
  int        m_cnt, m_cmp0, m_cmp1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ovf = 0; m_tog = 0; m_irq = 0;
      s1 = 0; s2 = 0; s3 = 0; m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0;
    end else begin
      bit run, edg, h, ovs, ecl;
      int grp;
      grp = m_mode >> 1;
      run = (grp != 0);
      edg = (edge_sel[0] && s2 && !s3) || (edge_sel[1] && !s2 && s3);
      h   = run && tick && (m_cnt == m_cmp0 || m_cnt == m_cmp1);
      ecl = (grp == 2) && edg;
      ovs = run && tick && (m_cnt == 65535) && !ecl;
      m_tog = m_tog ^ (run && (h || (m_mode[0] && edg)));
      m_irq = h;
      if (!run || ecl) m_cnt = 0;
      else if (tick) m_cnt = (grp == 3 && m_cnt == m_cmp0) ? 0 : (m_cnt + 1) % 65536;
      if (wr_en && wr_addr == 0) begin
        bit [2:0] nm;
        nm = wr_data[3:1];
        if (!run || (nm >> 1) == 0 || nm == m_mode) m_mode = nm;
        m_ovf = wr_data[0] | ovs;
      end else if (ovs) m_ovf = 1;
      if (wr_en && wr_addr == 1) m_cmp0 = wr_data;
      if (wr_en && wr_addr == 2) m_cmp1 = wr_data;
      s3 = s2; s2 = s1; s1 = ext_in;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      string tg;
      case (m_mode >> 1)
        0: tg = "R2 count"; 1: tg = "R3 count";
        2: tg = "R4 count"; default: tg = "R5 count";
      endcase
      case (rd_addr)
        2'd0: begin exp_rd = {m_mode, m_ovf}; tg = "R1 R8 R9 ctrl"; end
        2'd1: exp_rd = m_cmp0;
        2'd2: exp_rd = m_cmp1;
        default: exp_rd = m_cnt;
      endcase
      chk(tg, rd_data, exp_rd);
      chk("R7 toggle", tog_out, m_tog);
      chk("R6 irq", irq, m_irq);
    end
  end

  task automatic idle(input int n, input int tick_pct, input int ext_pct);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wr_en = 0;
      tick = (($urandom % 100) < tick_pct);
      if (($urandom % 100) < ext_pct) ext_in = ~ext_in;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    @(posedge clk); #2;
    wr_en = 0; rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    #1 rd_addr = 2'd3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset values
    rd_chk("R1 ctrl reset", 2'd0, 0);
    rd_chk("R1 cmp0 reset", 2'd1, 0);
    chk("R7 toggle reset", tog_out, 0);
    chk("R6 irq reset", irq, 0);

    // R2 stopped with ticks and edges
    wr(2'd1, 16'd5); wr(2'd2, 16'd2);
    rd_chk("R1 cmp1 readback", 2'd2, 2);
    wr(2'd0, 16'h0002);          // mode 001
    idle(40, 90, 30);
    rd_chk("R2 counter held", 2'd3, 0);

    // R3 free-running, mode 010, then R9 locked-mode write
    wr(2'd0, 16'h0004);
    idle(200, 70, 20);
    wr(2'd0, 16'h000C);          // attempt to switch to 110 while running
    rd_chk("R9 mode kept", 2'd0, 16'h0004);
    wr(2'd0, 16'h0006);          // 011 same group, different code: ignored
    rd_chk("R9 mode kept odd", 2'd0, 16'h0004);

    // R3 R8 wrap and overflow with steady ticks
    idle(65600, 100, 0);
    rd_chk("R8 overflow set", 2'd0, 16'h0005);
    wr(2'd0, 16'h0004);          // clear flag, same mode
    rd_chk("R9 R8 flag cleared", 2'd0, 16'h0004);

    // stop always allowed, then mode 011
    wr(2'd0, 16'h0000);
    rd_chk("R9 stop accepted", 2'd0, 0);
    wr(2'd0, 16'h0006);
    edge_sel = 2'b11;
    idle(300, 60, 25);

    // R4 R10 edge-clear modes and edge selection
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0008);          // 100
    edge_sel = 2'b01;
    idle(400, 80, 3);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h000A);          // 101
    edge_sel = 2'b10;
    idle(400, 80, 3);
    // R10 latency: rising edge with tick low clears on the third edge
    edge_sel = 2'b01;
    ext_in = 0;
    idle(20, 100, 0);
    @(posedge clk); #2 tick = 0; ext_in = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk("R10 not yet cleared", (rd_data != 0), 1);
    @(posedge clk);
    @(negedge clk) chk("R10 R4 cleared on third edge", rd_data, 0);
    // R10 no edges qualified
    edge_sel = 2'b00;
    idle(200, 90, 30);
    edge_sel = 2'b11;
    idle(200, 90, 10);

    // R5 match-clear modes
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd9); wr(2'd2, 16'd4);
    wr(2'd0, 16'h000C);          // 110
    idle(300, 75, 20);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h000E);          // 111
    idle(300, 75, 20);
    // R8 compare 0 at FFFF in mode 110
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h000C);
    idle(65550, 100, 0);
    rd_chk("R8 overflow with cmp0 FFFF", 2'd0, 16'h000D);
    chk("R5 counter restarted", (rd_data == 0), 0);

    idle(5, 100, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule